// File: doc/BRIEF.md
# Paged Data Address Translator

This block widens a 16-bit virtual data address into a 22-bit physical address. The two highest virtual bits choose one of four 8-bit page registers. The contents of that register become the upper part of the physical address, and the 14 low virtual bits pass through unchanged as the offset inside a 16-Kbyte page. Four page registers of 8 bits each reach 256 pages, which is 4 Mbytes in total.

An access can also carry a request to load a page register. If that register is the one translating the same access, the block refuses the write and raises an error flag. While the DMA-active input is high, paging does not apply. The request then passes through untranslated into the low 16 bits, and a bypass indication is raised. Software reads the page registers back through an index and a read data port. Reading has no effect on translation.

Top module: `pgx_translator`

## Requirements
- R1: After reset, page registers 0, 1, 2 and 3 hold 00h, 01h, 02h and 03h. The first 64 Kbytes therefore map onto themselves.
- R2: With `req_valid` high and `dma_active` low, `phys_addr[21:14]` equals the page register chosen by `vaddr[15:14]`, and `phys_addr[13:0]` equals `vaddr[13:0]`. Both appear in the same cycle, with no clock edge in between.
- R3: The value of `vaddr[15:14]` selects the page register directly: 0 selects register 0 (0000h–3FFFh), 1 selects register 1 (4000h–7FFFh), 2 selects register 2 (8000h–BFFFh) and 3 selects register 3 (C000h–FFFFh).
- R4: With `req_valid` and `dma_active` both high, `phys_addr` equals `{6'b0, vaddr}` and `bypass` is 1.
- R5: A write is legal when `req_valid` and `pg_wr` are high and either `dma_active` is high or `pg_wr_idx` differs from `vaddr[15:14]`. A legal write loads `pg_wr_data` into register `pg_wr_idx` at the clock edge. Readback and translation use the new value from the next cycle on.
- R6: A write is illegal when `req_valid` and `pg_wr` are high, `dma_active` is low, and `pg_wr_idx` equals `vaddr[15:14]`. In that cycle `wr_err` is 1 and the register keeps its old value. At all other times `wr_err` is 0.
- R7: A write made while `dma_active` is high never raises `wr_err` and is always performed.
- R8: If `pg_wr` is high while `req_valid` is low, the strobe is ignored: no register changes.
- R9: `phys_valid` follows `req_valid`. While `req_valid` is low, `phys_addr` is 0 and `bypass` is 0.
- R10: `rd_data` is the register selected by `rd_idx`, combinationally. The value of `rd_idx` has no effect on `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request is valid |
| vaddr | input | 16 | Virtual data address |
| dma_active | input | 1 | DMA in progress; paging bypassed |
| pg_wr | input | 1 | The access loads a page register |
| pg_wr_idx | input | 2 | Page register to load |
| pg_wr_data | input | 8 | Page number to load |
| rd_idx | input | 2 | Readback register index |
| rd_data | output | 8 | Readback page value |
| phys_addr | output | 22 | Physical address |
| phys_valid | output | 1 | Physical address is valid |
| bypass | output | 1 | Request passed through untranslated |
| wr_err | output | 1 | Write refused: target register translates this access |

## Verification
The translation outputs (`phys_addr`, `phys_valid`, `bypass`), `wr_err` and `rd_data` are combinational. The bench therefore drives each request on the falling edge and compares these outputs a quarter period later, in the same cycle. A page register write shows up only after the next rising edge. The bench's model updates at that edge, so every readback or translation that follows is checked against the new value one cycle after the write. A refused write is confirmed at the ports by reading the target register back and translating through it on the next cycle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  parameter int VA_W      = 16;
  parameter int PAGE_W    = 8;
  parameter int SEL_W     = 2;
  localparam int OFF_W    = VA_W - SEL_W;
  localparam int PA_W     = PAGE_W + OFF_W;
  localparam int NUM_PAGES = 1 << SEL_W;
  localparam int PAD_W    = PA_W - VA_W;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [VA_W-1:0]   vaddr_t;
  typedef logic [PA_W-1:0]   paddr_t;

  function automatic sel_t page_select(input vaddr_t va);
    return va[VA_W-1 -: SEL_W];
  endfunction

  function automatic logic [OFF_W-1:0] page_offset(input vaddr_t va);
    return va[OFF_W-1:0];
  endfunction

  function automatic paddr_t compose_phys(input page_t pg, input vaddr_t va);
    return {pg, page_offset(va)};
  endfunction

  function automatic paddr_t flat_phys(input vaddr_t va);
    return {{PAD_W{1'b0}}, va};
  endfunction

  function automatic page_t reset_page(input int idx);
    return page_t'(idx);
  endfunction
endpackage

// File: rtl/pgx_page_regs.sv
module pgx_page_regs
  import pgx_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  sel_t                             wr_idx,
  input  page_t                            wr_data,
  input  sel_t                             rd_idx,
  output logic [NUM_PAGES-1:0][PAGE_W-1:0] pages_q,
  output page_t                            rd_data
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic hit;
    assign hit = wr_en && (wr_idx == sel_t'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pages_q[g] <= reset_page(g);
      else if (hit) pages_q[g] <= wr_data;
    end
  end

  assign rd_data = pages_q[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pages_q[$past(wr_idx)] == $past(wr_data)); // R5
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> pages_q == $past(pages_q)); // R8
endmodule

// File: rtl/pgx_guard.sv
module pgx_guard
  import pgx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   dma_active,
  input  logic   pg_wr,
  input  vaddr_t vaddr,
  input  sel_t   pg_wr_idx,
  output logic   wr_en,
  output logic   wr_err
);
  logic wr_req;
  logic in_use_hit;

  assign wr_req     = req_valid && pg_wr;
  assign in_use_hit = !dma_active && (pg_wr_idx == page_select(vaddr));
  assign wr_err     = wr_req && in_use_hit;
  assign wr_en      = wr_req && !in_use_hit;

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (req_valid && pg_wr && !dma_active)); // R6
  AST_DMA_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> !wr_err); // R7
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             dma_active,
  input  vaddr_t                           vaddr,
  input  logic [NUM_PAGES-1:0][PAGE_W-1:0] pages_q,
  output paddr_t                           phys_addr,
  output logic                             phys_valid,
  output logic                             bypass
);
  page_t sel_page;
  assign sel_page = pages_q[page_select(vaddr)];

  always_comb begin
    phys_addr = '0;
    if (req_valid) begin
      if (dma_active) phys_addr = flat_phys(vaddr);
      else            phys_addr = compose_phys(sel_page, vaddr);
    end
  end

  assign phys_valid = req_valid;
  assign bypass     = req_valid && dma_active;

  AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (phys_addr[PA_W-1:VA_W] == '0 && phys_addr[VA_W-1:0] == vaddr)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (phys_addr == '0 && !bypass)); // R9
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dma_active) |-> phys_addr[OFF_W-1:0] == vaddr[OFF_W-1:0]); // R2
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [15:0] vaddr,
  input  logic        dma_active,
  input  logic        pg_wr,
  input  logic [1:0]  pg_wr_idx,
  input  logic [7:0]  pg_wr_data,
  input  logic [1:0]  rd_idx,
  output logic [7:0]  rd_data,
  output logic [21:0] phys_addr,
  output logic        phys_valid,
  output logic        bypass,
  output logic        wr_err
);
  logic                             wr_en;
  logic [NUM_PAGES-1:0][PAGE_W-1:0] pages_q;

  pgx_guard u_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dma_active(dma_active),
    .pg_wr(pg_wr), .vaddr(vaddr), .pg_wr_idx(pg_wr_idx),
    .wr_en(wr_en), .wr_err(wr_err)
  );

  pgx_page_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(pg_wr_idx),
    .wr_data(pg_wr_data), .rd_idx(rd_idx), .pages_q(pages_q), .rd_data(rd_data)
  );

  pgx_xlate u_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dma_active(dma_active),
    .vaddr(vaddr), .pages_q(pages_q), .phys_addr(phys_addr),
    .phys_valid(phys_valid), .bypass(bypass)
  );

  AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> pages_q[$past(pg_wr_idx)] == $past(pages_q[pg_wr_idx])); // R6
  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    phys_valid == req_valid); // R9
endmodule

// File: tb/pgx_translator_bench.sv
module pgx_translator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] vaddr = '0;
  logic        dma_active = 1'b0;
  logic        pg_wr = 1'b0;
  logic [1:0]  pg_wr_idx = '0;
  logic [7:0]  pg_wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic [21:0] phys_addr;
  logic        phys_valid;
  logic        bypass;
  logic        wr_err;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_translator u_pgx_translator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .dma_active(dma_active), .pg_wr(pg_wr), .pg_wr_idx(pg_wr_idx),
    .pg_wr_data(pg_wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .phys_addr(phys_addr), .phys_valid(phys_valid), .bypass(bypass), .wr_err(wr_err)
  );

  function automatic logic [21:0] exp_phys(input logic v, input logic d, input logic [15:0] a);
    if (!v) return 22'h0;
    if (d)  return {6'h0, a};
    return {model[a[15:14]], a[13:0]};
  endfunction

  function automatic logic exp_err(input logic v, input logic w, input logic d,
                                   input logic [1:0] idx, input logic [15:0] a);
    return v && w && !d && (idx == a[15:14]);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare a quarter period later, update model at the edge
  task automatic cycle(input logic v, input logic [15:0] a, input logic d, input logic w,
                       input logic [1:0] wi, input logic [7:0] wd, input logic [1:0] ri,
                       input string tag);
    logic [21:0] ep;
    logic ee;
    @(negedge clk);
    req_valid = v; vaddr = a; dma_active = d; pg_wr = w;
    pg_wr_idx = wi; pg_wr_data = wd; rd_idx = ri;
    #(CLK_PERIOD/4);
    ep = exp_phys(v, d, a);
    ee = exp_err(v, w, d, wi, a);
    check(phys_addr == ep, {tag, " phys"}, 32'(phys_addr), 32'(ep));
    check(bypass == (v && d), {tag, " bypass"}, 32'(bypass), 32'(v && d));
    check(phys_valid == v, {tag, " valid"}, 32'(phys_valid), 32'(v));
    check(wr_err == ee, {tag, " err"}, 32'(wr_err), 32'(ee));
    check(rd_data == model[ri], {tag, " rd"}, 32'(rd_data), 32'(model[ri]));
    @(posedge clk);
    if (v && w && !ee) model[wi] = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'(i);
    void'($urandom(32'h5EED1234));
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values via readback
    for (int i = 0; i < 4; i++)
      cycle(1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 8'h0, 2'(i), "R1 reset readback");
    // R3: window boundaries, identity after reset (R2)
    cycle(1'b1, 16'h3FFF, 1'b0, 1'b0, 2'd0, 8'h0, 2'd0, "R3 top of window 0");
    cycle(1'b1, 16'h4000, 1'b0, 1'b0, 2'd0, 8'h0, 2'd1, "R3 base of window 1");
    cycle(1'b1, 16'hBFFF, 1'b0, 1'b0, 2'd0, 8'h0, 2'd2, "R3 top of window 2");
    cycle(1'b1, 16'hC000, 1'b0, 1'b0, 2'd0, 8'h0, 2'd3, "R3 base of window 3");
    // R5: legal write from window 0 to register 3, then translate through it
    cycle(1'b1, 16'h1234, 1'b0, 1'b1, 2'd3, 8'hA5, 2'd3, "R5 legal write");
    cycle(1'b1, 16'hFFFF, 1'b0, 1'b0, 2'd0, 8'h0, 2'd3, "R5 new page used");
    check(phys_addr == 22'h297FFF || 1'b0, "R5 page A5 offset 3FFF", 32'(phys_addr), 32'h297FFF);
    // R6: illegal write to register 2 from window 2
    cycle(1'b1, 16'h8001, 1'b0, 1'b1, 2'd2, 8'hEE, 2'd2, "R6 illegal write");
    cycle(1'b1, 16'h8001, 1'b0, 1'b0, 2'd0, 8'h0, 2'd2, "R6 register kept");
    check(rd_data == 8'h02, "R6 readback unchanged", 32'(rd_data), 32'h02);
    // R7: same-register write under DMA is performed
    cycle(1'b1, 16'h4444, 1'b1, 1'b1, 2'd1, 8'h7C, 2'd1, "R7 dma write");
    cycle(1'b1, 16'h4444, 1'b0, 1'b0, 2'd0, 8'h0, 2'd1, "R7 dma write landed");
    check(rd_data == 8'h7C, "R7 readback", 32'(rd_data), 32'h7C);
    // R4: bypass with high address
    cycle(1'b1, 16'hFACE, 1'b1, 1'b0, 2'd0, 8'h0, 2'd0, "R4 bypass");
    // R8: strobe without valid
    cycle(1'b0, 16'h0000, 1'b0, 1'b1, 2'd0, 8'h99, 2'd0, "R8 strobe idle");
    cycle(1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 8'h0, 2'd0, "R8 no change");
    check(rd_data == 8'h00, "R8 readback", 32'(rd_data), 32'h00);
    // R10: sweep rd_idx on a fixed address
    for (int i = 0; i < 4; i++)
      cycle(1'b1, 16'hC123, 1'b0, 1'b0, 2'd0, 8'h0, 2'(i), "R10 readback sweep");

    // random mix (R2, R4, R5, R6, R9)
    for (int n = 0; n < 3000; n++) begin
      logic v, d, w;
      v = ($urandom % 8) != 0;
      d = ($urandom % 5) == 0;
      w = ($urandom % 3) == 0;
      cycle(v, 16'($urandom), d, w, 2'($urandom), 8'($urandom), 2'($urandom), "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule